// File: doc/BRIEF.md
# Code-Density Delay-Line Calibrator

This block builds the tap-to-time table of a delay-line time-to-digital converter by statistics rather than by assuming that every tap is equally long. While it runs, every channel's delay line is fed from a source of random pulses that bears no relation to the clock. Each raw tap code that the encoder reports is counted in a histogram bin. A long tap catches more of these random events than a short one, so its bin fills faster.

Once a fixed, power-of-two number of hits has arrived, the engine walks the bins in tap order and keeps a running sum. For each tap it writes one table entry: the time of the centre of that tap, as a fraction of the clock period. Because the hit total is a power of two, the scaling to the fraction is a shift. One engine serves all channels. The table write port is broadcast to all of them, and the input steering is applied to every channel at once.

The engine starts by itself when reset is released, and again on a recalibrate command. A busy flag covers the whole run. A debug port reads any histogram bin at any time, and a debug input can hold the delay lines on the random source even when no calibration is running.

Top module: `dl_code_density_cal`

## Requirements
- R1: `busy_o` is high from reset until the cycle after the last table write, then stays low until the next recalibrate command.
- R2: Every bit of `line_in_o` equals `cal_src_i` while `busy_o` or `force_cal_i` is high; otherwise `line_in_o` equals `chan_in_i`.
- R3: During collection, each cycle with `hit_valid_i` high adds one to the bin selected by `hit_code_i`. Hits that arrive outside collection change no bin.
- R4: A bin that holds 2^BIN_W-1 keeps that value when further hits land on it. Such hits still count towards the total.
- R5: Collection ends with the 2^HITS_LOG2-th valid hit. On the next clock edge the first table write (`lut_we_o`=1, `lut_addr_o`=0) appears.
- R6: The walk issues exactly 2^TAP_W writes in consecutive cycles, with addresses 0, 1, ... 2^TAP_W-1 in that order.
- R7: The entry for tap i equals floor((2*S_i + B_i) * 2^FRAC_W / 2^(HITS_LOG2+1)), clamped to 2^FRAC_W-1. Here S_i is the sum of bins 0..i-1 and B_i is bin i.
- R8: A cycle with `recal_i` high clears all bins, restarts the hit count and returns to collection. It takes priority over a hit or a table write in the same cycle, and that hit is not counted.
- R9: `dbg_bin_o` shows, in the same cycle, the bin selected by `dbg_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| recal_i | input | 1 | Full recalibrate command |
| force_cal_i | input | 1 | Debug: hold delay lines on the random source |
| chan_in_i | input | CH_N | Channel signals in normal operation |
| cal_src_i | input | 1 | Random calibration pulses |
| line_in_o | output | CH_N | Selected delay-line inputs |
| hit_valid_i | input | 1 | Encoder reports a code |
| hit_code_i | input | TAP_W | Raw tap code |
| busy_o | output | 1 | Calibration in progress |
| lut_we_o | output | 1 | Table write strobe |
| lut_addr_o | output | TAP_W | Table address (tap code) |
| lut_data_o | output | FRAC_W | Fine-time fraction |
| dbg_addr_i | input | TAP_W | Debug bin select |
| dbg_bin_o | output | BIN_W | Debug bin value |

## Verification
The recalibrate command and the final hit of collection can fall in the same cycle. Then the walk must not start, and the histogram must be wiped instead of receiving that hit. The bench provokes this by sending one hit fewer than the total, then raising `recal_i` together with the last hit. It judges the outcome one cycle later: no table write, busy still high, and every bin reading zero through the debug port. A complete run afterwards must need the full number of hits again.

// File: rtl/dl_cal_pkg.sv
package dl_cal_pkg;
  typedef enum logic [1:0] {
    CAL_COLLECT = 2'd0,
    CAL_WALK    = 2'd1,
    CAL_IDLE    = 2'd2
  } cal_state_e;
endpackage

// File: rtl/dl_cal_hist.sv
module dl_cal_hist #(
  parameter int TAP_W = 4,
  parameter int BIN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [TAP_W-1:0] code_i,
  input  logic [TAP_W-1:0] walk_addr_i,
  output logic [BIN_W-1:0] walk_bin_o,
  input  logic [TAP_W-1:0] dbg_addr_i,
  output logic [BIN_W-1:0] dbg_bin_o
);
  localparam int TAPS = 1 << TAP_W;
  localparam logic [BIN_W-1:0] BIN_MAX = '1;

  logic [BIN_W-1:0] bin_q [TAPS];
  logic [BIN_W-1:0] bin_d [TAPS];

  always_comb begin
    for (int i = 0; i < TAPS; i++) begin
      bin_d[i] = bin_q[i];
      if (clr_i) begin
        bin_d[i] = '0;
      end else if (inc_i && (code_i == TAP_W'(i)) && (bin_q[i] != BIN_MAX)) begin
        bin_d[i] = bin_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) bin_q[i] <= '0;
    end else begin
      for (int i = 0; i < TAPS; i++) bin_q[i] <= bin_d[i];
    end
  end

  assign walk_bin_o = bin_q[walk_addr_i];
  assign dbg_bin_o  = bin_q[dbg_addr_i];

  logic any_nz;
  always_comb begin
    any_nz = 1'b0;
    for (int i = 0; i < TAPS; i++) any_nz = any_nz | (bin_q[i] != '0);
  end

  p_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i && bin_q[code_i] == BIN_MAX) |=> bin_q[$past(code_i)] == BIN_MAX);

  p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !any_nz);
endmodule

// File: rtl/dl_cal_walk.sv
module dl_cal_walk #(
  parameter int TAP_W     = 4,
  parameter int BIN_W     = 7,
  parameter int HITS_LOG2 = 8,
  parameter int FRAC_W    = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              en_i,
  input  logic [BIN_W-1:0]  bin_i,
  output logic [TAP_W-1:0]  idx_o,
  output logic              last_o,
  output logic [FRAC_W-1:0] frac_o
);
  localparam int ACC_W  = HITS_LOG2 + 1;
  localparam int NUM_W  = ACC_W + 1;
  localparam int WIDE_W = NUM_W + FRAC_W;
  localparam logic [FRAC_W-1:0] FRAC_MAX = '1;
  localparam logic [TAP_W-1:0]  IDX_LAST = '1;

  logic [ACC_W-1:0]  acc_q, acc_d;
  logic [TAP_W-1:0]  idx_q, idx_d;
  logic [NUM_W-1:0]  num;
  logic [WIDE_W-1:0] wide;

  always_comb begin
    acc_d = acc_q;
    idx_d = idx_q;
    if (start_i) begin
      acc_d = '0;
      idx_d = '0;
    end else if (en_i) begin
      acc_d = acc_q + ACC_W'(bin_i);
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      idx_q <= '0;
    end else begin
      acc_q <= acc_d;
      idx_q <= idx_d;
    end
  end

  // centre of tap: running sum plus half of this bin, scaled by a shift
  always_comb begin
    num  = {acc_q, 1'b0} + NUM_W'(bin_i);
    wide = {num, {FRAC_W{1'b0}}} >> (HITS_LOG2 + 1);
    if (wide > {{NUM_W{1'b0}}, FRAC_MAX}) frac_o = FRAC_MAX;
    else                                  frac_o = wide[FRAC_W-1:0];
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == IDX_LAST);

  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && $past(en_i) && !$past(start_i)) |-> idx_q == $past(idx_q) + 1'b1);

  p_monotonic_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && $past(en_i) && idx_q != '0) |-> frac_o >= $past(frac_o));
endmodule

// File: rtl/dl_cal_ctrl.sv
module dl_cal_ctrl
  import dl_cal_pkg::*;
#(
  parameter int HITS_LOG2 = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic recal_i,
  input  logic hit_valid_i,
  input  logic last_i,
  output logic busy_o,
  output logic clr_o,
  output logic inc_o,
  output logic walk_start_o,
  output logic walk_en_o
);
  localparam logic [HITS_LOG2-1:0] CNT_LAST = '1;

  cal_state_e           state_q, state_d;
  logic [HITS_LOG2-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d      = state_q;
    cnt_d        = cnt_q;
    clr_o        = 1'b0;
    walk_start_o = 1'b0;
    if (recal_i) begin
      state_d = CAL_COLLECT;
      cnt_d   = '0;
      clr_o   = 1'b1;
    end else begin
      case (state_q)
        CAL_COLLECT: if (hit_valid_i) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) begin
            state_d      = CAL_WALK;
            walk_start_o = 1'b1;
          end
        end
        CAL_WALK:    if (last_i) state_d = CAL_IDLE;
        default:     state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CAL_COLLECT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign inc_o     = (state_q == CAL_COLLECT) && hit_valid_i && !recal_i;
  assign walk_en_o = (state_q == CAL_WALK) && !recal_i;
  assign busy_o    = (state_q != CAL_IDLE);

  p_walk_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CAL_COLLECT && hit_valid_i && !recal_i && cnt_q == CNT_LAST)
      |=> (state_q == CAL_WALK));

  p_recal_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    recal_i |=> (state_q == CAL_COLLECT && cnt_q == '0));
endmodule

// File: rtl/dl_code_density_cal.sv
module dl_code_density_cal #(
  parameter int CH_N      = 2,
  parameter int TAP_W     = 4,
  parameter int BIN_W     = 7,
  parameter int HITS_LOG2 = 8,
  parameter int FRAC_W    = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              recal_i,
  input  logic              force_cal_i,
  input  logic [CH_N-1:0]   chan_in_i,
  input  logic              cal_src_i,
  output logic [CH_N-1:0]   line_in_o,
  input  logic              hit_valid_i,
  input  logic [TAP_W-1:0]  hit_code_i,
  output logic              busy_o,
  output logic              lut_we_o,
  output logic [TAP_W-1:0]  lut_addr_o,
  output logic [FRAC_W-1:0] lut_data_o,
  input  logic [TAP_W-1:0]  dbg_addr_i,
  output logic [BIN_W-1:0]  dbg_bin_o
);
  localparam logic [TAP_W-1:0] ADDR_LAST = '1;

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic             clr, inc, walk_start, walk_en, last;
  logic [TAP_W-1:0] idx;
  logic [BIN_W-1:0] walk_bin;

  dl_cal_ctrl #(.HITS_LOG2(HITS_LOG2)) u_ctrl (
    .clk(clk), .rst_n(rst_core_n), .recal_i(recal_i), .hit_valid_i(hit_valid_i),
    .last_i(last), .busy_o(busy_o), .clr_o(clr), .inc_o(inc),
    .walk_start_o(walk_start), .walk_en_o(walk_en)
  );

  dl_cal_hist #(.TAP_W(TAP_W), .BIN_W(BIN_W)) u_hist (
    .clk(clk), .rst_n(rst_core_n), .clr_i(clr), .inc_i(inc), .code_i(hit_code_i),
    .walk_addr_i(idx), .walk_bin_o(walk_bin),
    .dbg_addr_i(dbg_addr_i), .dbg_bin_o(dbg_bin_o)
  );

  dl_cal_walk #(.TAP_W(TAP_W), .BIN_W(BIN_W), .HITS_LOG2(HITS_LOG2), .FRAC_W(FRAC_W)) u_walk (
    .clk(clk), .rst_n(rst_core_n), .start_i(walk_start), .en_i(walk_en),
    .bin_i(walk_bin), .idx_o(idx), .last_o(last), .frac_o(lut_data_o)
  );

  assign lut_we_o   = walk_en;
  assign lut_addr_o = idx;

  for (genvar c = 0; c < CH_N; c++) begin : g_steer
    assign line_in_o[c] = (busy_o || force_cal_i) ? cal_src_i : chan_in_i[c];
  end

  p_busy_end_r1: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(busy_o) |-> ($past(lut_we_o) && $past(lut_addr_o) == ADDR_LAST));
endmodule

// File: tb/dl_code_density_cal_bench.sv
module dl_code_density_cal_bench;
  localparam int CH_N = 2, TAP_W = 4, BIN_W = 7, HITS_LOG2 = 8, FRAC_W = 13;
  localparam int TAPS = 1 << TAP_W;
  localparam int HITS = 1 << HITS_LOG2;
  localparam int BIN_MAX = (1 << BIN_W) - 1;
  localparam int FRAC_MAX = (1 << FRAC_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic recal_i = 1'b0, force_cal_i = 1'b0, cal_src_i = 1'b0, hit_valid_i = 1'b0;
  logic [CH_N-1:0] chan_in_i = '0;
  logic [TAP_W-1:0] hit_code_i = '0, dbg_addr_i = '0;
  logic [CH_N-1:0] line_in_o;
  logic busy_o, lut_we_o;
  logic [TAP_W-1:0] lut_addr_o;
  logic [FRAC_W-1:0] lut_data_o;
  logic [BIN_W-1:0] dbg_bin_o;

  always #4 clk = ~clk;

  dl_code_density_cal #(.CH_N(CH_N), .TAP_W(TAP_W), .BIN_W(BIN_W),
    .HITS_LOG2(HITS_LOG2), .FRAC_W(FRAC_W)) u_dl_code_density_cal (
    .clk(clk), .rst_n(rst_n), .recal_i(recal_i), .force_cal_i(force_cal_i),
    .chan_in_i(chan_in_i), .cal_src_i(cal_src_i), .line_in_o(line_in_o),
    .hit_valid_i(hit_valid_i), .hit_code_i(hit_code_i), .busy_o(busy_o),
    .lut_we_o(lut_we_o), .lut_addr_o(lut_addr_o), .lut_data_o(lut_data_o),
    .dbg_addr_i(dbg_addr_i), .dbg_bin_o(dbg_bin_o)
  );

  int checks = 0, failures = 0, cycles = 0;
  int wr_cnt = 0;
  int cap [TAPS];
  int seq [TAPS];
  int model [TAPS];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (lut_we_o) begin
      if (wr_cnt < TAPS) begin
        cap[lut_addr_o] = int'(lut_data_o);
        seq[wr_cnt] = int'(lut_addr_o);
      end
      wr_cnt++;
    end
  end

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic int code_of(int mode, int k);
    case (mode)
      0: return k % TAPS;
      1: return 3;
      default: return k % 4;
    endcase
  endfunction

  function automatic int expect_frac(int i);
    int s = 0;
    int v;
    for (int j = 0; j < i; j++) s += model[j];
    v = ((2 * s + model[i]) * (1 << FRAC_W)) / (2 * HITS);
    return (v > FRAC_MAX) ? FRAC_MAX : v;
  endfunction

  task automatic pulse_recal();
    @(negedge clk); recal_i = 1'b1;
    @(negedge clk); recal_i = 1'b0;
  endtask

  task automatic run_cal(int mode, string tag);
    for (int i = 0; i < TAPS; i++) begin model[i] = 0; cap[i] = -1; seq[i] = -1; end
    wr_cnt = 0;
    for (int k = 0; k < HITS; k++) begin
      @(negedge clk);
      if (k == HITS - 1) chk({"R5 no early write ", tag}, int'(lut_we_o), 0);
      hit_valid_i = 1'b1;
      hit_code_i  = TAP_W'(code_of(mode, k));
      if (model[code_of(mode, k)] < BIN_MAX) model[code_of(mode, k)]++;
    end
    @(negedge clk);
    hit_valid_i = 1'b0;
    chk({"R5 first write strobe ", tag}, int'(lut_we_o), 1);
    chk({"R5 first write addr ", tag}, int'(lut_addr_o), 0);
    for (int g = 0; g < 40 && busy_o; g++) @(negedge clk);
    chk({"R1 busy low after walk ", tag}, int'(busy_o), 0);
    chk({"R6 write count ", tag}, wr_cnt, TAPS);
    for (int i = 0; i < TAPS; i++) begin
      chk({"R6 write order ", tag}, seq[i], i);
      chk({"R7 table entry ", tag}, cap[i], expect_frac(i));
      dbg_addr_i = TAP_W'(i);
      #1;
      chk({"R9 debug bin ", tag}, int'(dbg_bin_o), model[i]);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 busy during reset", int'(busy_o), 1);
    chk("R6 no write during reset", int'(lut_we_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy after reset", int'(busy_o), 1);
    cal_src_i = 1'b1; chan_in_i = 2'b00; #1;
    chk("R2 cal source while busy", int'(line_in_o), 3);
  endtask

  task automatic t_uniform();
    run_cal(0, "uniform");
  endtask

  task automatic t_idle_ignore();
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); hit_valid_i = 1'b1; hit_code_i = 4'd5;
      chk("R6 no write while idle", int'(lut_we_o), 0);
    end
    @(negedge clk); hit_valid_i = 1'b0;
    dbg_addr_i = 4'd5; #1;
    chk("R3 idle hits ignored", int'(dbg_bin_o), HITS / TAPS);
    chk("R1 busy stays low", int'(busy_o), 0);
  endtask

  task automatic t_steer();
    cal_src_i = 1'b0; chan_in_i = 2'b10; force_cal_i = 1'b0; #1;
    chk("R2 channel pass when idle", int'(line_in_o), 2);
    force_cal_i = 1'b1; cal_src_i = 1'b1; #1;
    chk("R2 forced cal source", int'(line_in_o), 3);
    cal_src_i = 1'b0; #1;
    chk("R2 forced cal source low", int'(line_in_o), 0);
    force_cal_i = 1'b0; #1;
    chk("R2 release force", int'(line_in_o), 2);
  endtask

  task automatic t_collision();
    pulse_recal();
    chk("R8 busy after recal", int'(busy_o), 1);
    for (int k = 0; k < HITS - 1; k++) begin
      @(negedge clk); hit_valid_i = 1'b1; hit_code_i = TAP_W'(k % TAPS);
    end
    @(negedge clk);
    dbg_addr_i = 4'd1; #1;
    chk("R3 bins counting", int'(dbg_bin_o), (HITS - 1) / TAPS + 1);
    recal_i = 1'b1; hit_code_i = 4'd2;
    @(negedge clk);
    recal_i = 1'b0; hit_valid_i = 1'b0;
    chk("R8 walk suppressed", int'(lut_we_o), 0);
    chk("R8 busy held", int'(busy_o), 1);
    for (int i = 0; i < TAPS; i++) begin
      dbg_addr_i = TAP_W'(i); #1;
      chk("R8 bins wiped", int'(dbg_bin_o), 0);
    end
  endtask

  task automatic t_saturate();
    run_cal(1, "saturate");
    dbg_addr_i = 4'd3; #1;
    chk("R4 bin held at max", int'(dbg_bin_o), BIN_MAX);
  endtask

  task automatic t_clamp();
    pulse_recal();
    run_cal(2, "clamp");
    chk("R7 clamp last entry", cap[TAPS-1], FRAC_MAX);
  endtask

  initial begin
    t_reset();
    t_uniform();
    t_idle_ignore();
    t_steer();
    t_collision();
    t_saturate();
    t_clamp();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule